// File: doc/BRIEF.md
# Byte Program-and-Verify Sequencer for a UV-Erasable EPROM

This controller writes an 8192-byte, 13-bit-addressed ultraviolet-erasable EPROM one byte at a time. A request carrying an address and a data byte is taken over a valid/ready handshake. The sequencer then places the address and data on the device pins, keeps the device's read enable inactive, and raises the program line for a fixed number of clock cycles. Afterwards it releases its data driver, enables the device output, captures the stored byte and compares it with the requested value.

Programming can only turn ones into zeros, and a freshly erased part reads all ones. A read-back that still shows a one where a zero is wanted earns another pulse, up to a parameterised retry limit. A read-back that shows a zero where a one is wanted can never be repaired, so it fails at once. A byte of all ones needs no pulse and is only verified. Every request ends with a one-cycle report that carries a fail flag and the byte's address.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, reqReady is 1, romPgm is 0, romOeN is 1, romDataOe is 0 and doneValid is 0.
- R2: Each program pulse keeps romPgm at 1 for exactly PULSE_CYC consecutive cycles (default 10,000,000 cycles, i.e. 50 ms at 200 MHz). Throughout the pulse romOeN is 1, romDataOe is 1, and romAddr and romDataOut hold the request's address and data.
- R3: romDataOe and an active romOeN (0) are never present together, and at least one cycle with romDataOe at 0 separates the end of driving from the read.
- R4: After every pulse, the byte is read back with romOeN at 0. If it equals the requested data, the request is reported with doneFail at 0.
- R5: If the read-back differs only in bits that are still 1 where the request has 0, the byte is pulsed again.
- R6: A byte gets at most 1+MAX_RETRY pulses. If it still mismatches after the last one, it is reported with doneFail at 1 and doneAddr set to its address.
- R7: A request whose data is 0xFF gets no pulse. It is only verified.
- R8: A read-back with a 0 in any bit where the request has 1 is reported as failed at once, with no further pulse.
- R9: A request is taken on a cycle with reqValid and reqReady both 1, and reqReady is 1 only while the sequencer is idle. doneValid is a one-cycle pulse. A request waiting at that moment is taken in the same cycle as the report.
- R10: An asynchronous reset during a pulse drops romPgm at once and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A byte request is offered |
| reqReady | output | 1 | Sequencer is idle and takes the request |
| reqAddr | input | 13 | Target byte address |
| reqData | input | 8 | Value to program |
| romAddr | output | 13 | Address pins of the device |
| romDataOut | output | 8 | Data driven to the device |
| romDataOe | output | 1 | Enable of the data driver |
| romDataIn | input | 8 | Data read from the device |
| romOeN | output | 1 | Device read enable, active low |
| romPgm | output | 1 | Combined chip-enable/program pulse, active high |
| doneValid | output | 1 | One-cycle completion report |
| doneFail | output | 1 | Reported byte failed |
| doneAddr | output | 13 | Address of the reported byte |

## Verification
The completion report of one byte and the acceptance of the next can fall in the same clock edge. The bench provokes this by keeping reqValid high with the following request in place while the current byte finishes. It judges the overlap in two ways. Every report must carry the finishing byte's address and outcome rather than the newcomer's. The newcomer must then receive exactly the pulses its table entry predicts, counted from the edge of that report.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_TURN, S_READ, S_CHECK
  } seqState_t;

  typedef struct packed {
    logic latchReq;
    logic driveBus;
    logic pgmOn;
    logic readOn;
    logic capture;
    logic cntClr;
    logic tryInc;
    logic report;
    logic failFlag;
  } seqStrobe_t;

endpackage

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import eprom_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       reqErased,
  input  logic       pulseLast,
  input  logic       readMatch,
  input  logic       stuckZero,
  input  logic       triesUsed,
  output seqStrobe_t strb
);

  seqState_t state, stateNext;
  logic      fire;

  assign reqReady = (state == S_IDLE);
  assign fire     = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      S_IDLE: begin
        if (fire) begin
          strb.latchReq = 1'b1;
          stateNext     = reqErased ? S_TURN : S_SETUP;
        end
      end
      S_SETUP: begin
        strb.driveBus = 1'b1;
        strb.cntClr   = 1'b1;
        stateNext     = S_PULSE;
      end
      S_PULSE: begin
        strb.driveBus = 1'b1;
        strb.pgmOn    = 1'b1;
        if (pulseLast) stateNext = S_HOLD;
      end
      S_HOLD: begin
        strb.driveBus = 1'b1;
        strb.tryInc   = 1'b1;
        stateNext     = S_TURN;
      end
      S_TURN: stateNext = S_READ;
      S_READ: begin
        strb.readOn  = 1'b1;
        strb.capture = 1'b1;
        stateNext    = S_CHECK;
      end
      S_CHECK: begin
        if (readMatch) begin
          strb.report = 1'b1;
          stateNext   = S_IDLE;
        end else if (stuckZero || triesUsed) begin
          strb.report   = 1'b1;
          strb.failFlag = 1'b1;
          stateNext     = S_IDLE;
        end else begin
          stateNext = S_SETUP;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  AST_PULSE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PULSE && $past(state) != S_PULSE) |-> $past(state) == S_SETUP); // R2

  AST_STUCK_NO_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && stuckZero) |=> state == S_IDLE); // R8

  AST_READY_NOT_PULSING: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !strb.pgmOn); // R9

endmodule

// File: rtl/eprom_prog_dp.sv
module eprom_prog_dp
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 10_000_000,
  parameter int MAX_RETRY = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] romDataIn,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] romDataOut,
  output logic              romDataOe,
  output logic              romOeN,
  output logic              romPgm,
  output logic              reqErased,
  output logic              pulseLast,
  output logic              readMatch,
  output logic              stuckZero,
  output logic              triesUsed,
  output logic              doneValid,
  output logic              doneFail,
  output logic [ADDR_W-1:0] doneAddr
);

  localparam int PCNT_W = $clog2(PULSE_CYC + 1);
  localparam int TRY_W  = $clog2(MAX_RETRY + 2);
  localparam logic [DATA_W-1:0] ERASED = '1;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ, rdQ;
  logic [PCNT_W-1:0] pulseCnt;
  logic [TRY_W-1:0]  tryCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      rdQ      <= '0;
      pulseCnt <= '0;
      tryCnt   <= '0;
    end else begin
      if (strb.latchReq) begin
        addrQ  <= reqAddr;
        dataQ  <= reqData;
        tryCnt <= '0;
      end
      if (strb.cntClr)      pulseCnt <= '0;
      else if (strb.pgmOn)  pulseCnt <= pulseCnt + 1'b1;
      if (strb.tryInc)      tryCnt <= tryCnt + 1'b1;
      if (strb.capture)     rdQ <= romDataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneFail  <= 1'b0;
      doneAddr  <= '0;
    end else begin
      doneValid <= strb.report;
      if (strb.report) begin
        doneFail <= strb.failFlag;
        doneAddr <= addrQ;
      end
    end
  end

  assign reqErased  = (reqData == ERASED);
  assign pulseLast  = (pulseCnt == PCNT_W'(PULSE_CYC - 1));
  assign readMatch  = (rdQ == dataQ);
  assign stuckZero  = |(dataQ & ~rdQ);
  assign triesUsed  = (tryCnt == TRY_W'(MAX_RETRY + 1));

  assign romAddr    = addrQ;
  assign romDataOut = dataQ;
  assign romDataOe  = strb.driveBus;
  assign romOeN     = ~strb.readOn;
  assign romPgm     = strb.pgmOn;

  AST_PGM_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    romPgm |-> (romDataOe && romOeN)); // R2

  AST_PINS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    romPgm |-> ($stable(romAddr) && $stable(romDataOut))); // R2

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    !(romDataOe && !romOeN)); // R3

  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tryCnt <= TRY_W'(MAX_RETRY + 1)); // R6

  AST_ERASED_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.report && tryCnt == '0) |-> dataQ == ERASED); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R9

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 10_000_000,
  parameter int MAX_RETRY = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] romDataOut,
  output logic              romDataOe,
  input  logic [DATA_W-1:0] romDataIn,
  output logic              romOeN,
  output logic              romPgm,
  output logic              doneValid,
  output logic              doneFail,
  output logic [ADDR_W-1:0] doneAddr
);

  seqStrobe_t strb;
  logic reqErased, pulseLast, readMatch, stuckZero, triesUsed;

  eprom_prog_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .reqErased (reqErased),
    .pulseLast (pulseLast),
    .readMatch (readMatch),
    .stuckZero (stuckZero),
    .triesUsed (triesUsed),
    .strb      (strb)
  );

  eprom_prog_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PULSE_CYC (PULSE_CYC),
    .MAX_RETRY (MAX_RETRY)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .romDataIn  (romDataIn),
    .romAddr    (romAddr),
    .romDataOut (romDataOut),
    .romDataOe  (romDataOe),
    .romOeN     (romOeN),
    .romPgm     (romPgm),
    .reqErased  (reqErased),
    .pulseLast  (pulseLast),
    .readMatch  (readMatch),
    .stuckZero  (stuckZero),
    .triesUsed  (triesUsed),
    .doneValid  (doneValid),
    .doneFail   (doneFail),
    .doneAddr   (doneAddr)
  );

endmodule

// File: tb/tb_eprom_prog_seq.sv
`timescale 1ns/1ps
module tb_eprom_prog_seq;

  localparam int PULSE = 8;
  localparam int RETRY = 3;
  localparam int NVEC  = 8;

  // {addr13, data8, init8, needPulses4, expFail1, expPulses4}
  localparam logic [37:0] VEC [0:NVEC-1] = '{
    {13'h0001, 8'hA5, 8'hFF, 4'd1, 1'b0, 4'd1},  // R4 single pulse
    {13'h0002, 8'h3C, 8'hFF, 4'd3, 1'b0, 4'd3},  // R5 retries
    {13'h0003, 8'hFF, 8'hFF, 4'd1, 1'b0, 4'd0},  // R7 erased skip
    {13'h0004, 8'hFF, 8'hFE, 4'd1, 1'b1, 4'd0},  // R7/R8 skip then fail
    {13'h0005, 8'h0F, 8'hFF, 4'd9, 1'b1, 4'd4},  // R6 exhausted
    {13'h0006, 8'hF0, 8'h7F, 4'd1, 1'b1, 4'd1},  // R8 stuck zero
    {13'h0007, 8'h00, 8'hFF, 4'd4, 1'b0, 4'd4},  // R6 last allowed
    {13'h1FFF, 8'h55, 8'hFF, 4'd2, 1'b0, 4'd2}   // R5 top address
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic        reqReady, romDataOe, romOeN, romPgm, doneValid, doneFail;
  logic [12:0] romAddr, doneAddr;
  logic [7:0]  romDataOut, romDataIn;

  always #2.5 clk = ~clk;

  eprom_prog_seq #(.PULSE_CYC(PULSE), .MAX_RETRY(RETRY)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .romAddr(romAddr),
    .romDataOut(romDataOut), .romDataOe(romDataOe), .romDataIn(romDataIn),
    .romOeN(romOeN), .romPgm(romPgm), .doneValid(doneValid),
    .doneFail(doneFail), .doneAddr(doneAddr)
  );

  // small device model indexed by the low six address bits
  logic [7:0] mem  [0:63];
  int         need [0:63];
  int         hits [0:63];
  assign romDataIn = (!romOeN && !romDataOe) ? mem[romAddr[5:0]] : 8'h00;

  int total = 0, bad = 0;
  int doneIdx = 0, pulsesSeen = 0, width = 0;
  int holdBad = 0, contendBad = 0;
  logic prevPgm = 1'b0, prevOe = 1'b0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      prevPgm = 1'b0; prevOe = 1'b0; width = 0;
    end else begin
      if (romPgm) begin
        width++;
        if (!prevPgm) pulsesSeen++;
        if (doneIdx < NVEC && (romAddr != VEC[doneIdx][37:25] ||
            romDataOut != VEC[doneIdx][24:17] || !romOeN || !romDataOe))
          holdBad++;
      end
      if (prevPgm && !romPgm) begin
        chk(width == PULSE, "R2 pulse width", width, PULSE);
        width = 0;
        hits[romAddr[5:0]]++;
        if (hits[romAddr[5:0]] >= need[romAddr[5:0]])
          mem[romAddr[5:0]] = mem[romAddr[5:0]] & romDataOut;
      end
      if ((romDataOe && !romOeN) || (prevOe && !romOeN)) contendBad++;
      if (doneValid && doneIdx < NVEC) begin
        chk(doneFail == VEC[doneIdx][4], "R4/R6/R8 fail flag", doneFail, VEC[doneIdx][4]);
        chk(doneAddr == VEC[doneIdx][37:25], "R6/R9 done address", doneAddr, VEC[doneIdx][37:25]);
        chk(pulsesSeen == int'(VEC[doneIdx][3:0]), "R5/R6/R7 pulse count",
            pulsesSeen, VEC[doneIdx][3:0]);
        pulsesSeen = 0;
        doneIdx++;
      end
      prevPgm = romPgm;
      prevOe  = romDataOe;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = 8'hFF; need[i] = 1; hits[i] = 0; end
    for (int i = 0; i < NVEC; i++) begin
      mem[VEC[i][30:25]]  = VEC[i][16:9];
      need[VEC[i][30:25]] = int'(VEC[i][8:5]);
    end
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready", reqReady, 1);
    chk(romPgm == 1'b0, "R1 pgm", romPgm, 0);
    chk(romOeN == 1'b1, "R1 oeN", romOeN, 1);
    chk(romDataOe == 1'b0, "R1 drive", romDataOe, 0);
    chk(doneValid == 1'b0, "R1 done", doneValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    // back-to-back requests: next one waits while the current byte reports (R9)
    for (int i = 0; i < NVEC; i++) begin
      reqValid = 1'b1;
      reqAddr  = VEC[i][37:25];
      reqData  = VEC[i][24:17];
      while (!reqReady) @(negedge clk);
      @(negedge clk);
    end
    reqValid = 1'b0;
    while (doneIdx < NVEC) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(holdBad == 0, "R2 bus hold during pulse", holdBad, 0);
    chk(contendBad == 0, "R3 driver released before read", contendBad, 0);
    // idle with no request: nothing moves
    repeat (10) @(negedge clk);
    chk(romPgm == 1'b0 && reqReady == 1'b1, "R9 idle stays", romPgm, 0);
    // reset in the middle of a pulse (R10)
    mem[9] = 8'hFF; need[9] = 1;
    reqValid = 1'b1; reqAddr = 13'h0009; reqData = 8'h12;
    @(negedge clk);
    reqValid = 1'b0;
    while (!romPgm) @(negedge clk);
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    #0.5;
    chk(romPgm == 1'b0, "R10 pgm drops", romPgm, 0);
    chk(reqReady == 1'b1, "R10 back to idle", reqReady, 1);
    chk(romDataOe == 1'b0, "R10 driver off", romDataOe, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(doneValid == 1'b0 && romPgm == 1'b0, "R10 quiet after reset", doneValid, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", doneIdx, NVEC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule